// File: doc/BRIEF.md
# Block Process-Call Slave Framing Engine

This block is the byte-level half of a two-wire management slave. It sits behind a bit-level front end that has already found start and stop conditions and assembled bytes. It takes one bus event per cycle and follows a combined transaction. The write half carries the target address, a command code, a write count M and M payload bytes. When checking is enabled, an integrity byte follows the payload. A repeated start then opens the read half: the address with the read bit, after which the engine itself sends a count N, N response bytes and a closing integrity byte.

Both integrity bytes are CRC-8 values held in one running register. The first covers the address byte through the last payload byte. The closing one covers every byte of the transaction except the first integrity byte. The payload is handed to a command handler with a one-cycle strobe at the repeated start. The handler's response is captured when the read address is accepted. A stop, an out-of-place start or a clock held low past the timeout limit abandons the frame and never strobes the handler.

Top module: `pcall_engine`

## Requirements
- R1: The first byte after a start is ACKed only when it equals {own_addr_i, 1'b0}. Any other value is NACKed, and the engine gives no ACK/NACK response at all to later bytes until the next start.
- R2: Each received byte in the write half gets an ACK/NACK response in the cycle after its event: ack_valid_o=1, with ack_o=1 for ACK. A write count of 0 or above MAX_WR is NACKed and the frame is dropped.
- R3: Integrity bytes are CRC-8 with polynomial 07h and initial value 00h. Each byte is processed most significant bit first.
- R4: With pec_en_i=1, the byte after payload byte M must equal the CRC over the address byte through payload byte M. A match is ACKed. A mismatch is NACKed, and the following repeated start produces no cmd_valid_o.
- R5: With pec_en_i=0, the repeated start follows payload byte M directly, and a byte received in that slot is NACKed.
- R6: cmd_valid_o pulses for one cycle, in the cycle after the repeated start event. With it, cmd_code_o, wr_len_o and wr_data_o are presented; payload byte j sits at wr_data_o[8j+7:8j].
- R7: After a repeated start, {own_addr_i, 1'b1} is ACKed and the response is captured. tx_byte_o then shows N, data 1..N and the closing CRC in turn. Each step happens in the cycle after a transmit-done event whose ev_byte_i[0] is 0. If ev_byte_i[0] is 1 (master NACK), tx_byte_o goes to FFh.
- R8: The closing CRC covers the write address, command, M, payload, read address, N and the response data, and leaves out the intermediate integrity byte.
- R9: A stop at any point, or a start in any state other than idle, done or awaiting the repeated start, returns the engine to idle. No cmd_valid_o is produced.
- R10: When scl_low_i has been 1 for TO_CYC consecutive clock edges, the engine returns to idle. This abort overrides a bus event that arrives in the same cycle.
- R11: After reset, ack_valid_o=0, cmd_valid_o=0 and tx_byte_o=FFh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ev_valid_i | input | 1 | A bus event is present this cycle |
| ev_kind_i | input | 2 | 00 received byte, 01 start or repeated start, 10 stop, 11 transmitted byte done |
| ev_byte_i | input | 8 | Received byte; for a transmit-done event, bit 0 is the master's ack bit (0 = ACK) |
| scl_low_i | input | 1 | Bus clock is currently held low |
| pec_en_i | input | 1 | Intermediate integrity byte expected; hold stable within a frame |
| own_addr_i | input | 7 | Own 7-bit slave address |
| ack_valid_o | output | 1 | ACK/NACK response for the byte received last cycle |
| ack_o | output | 1 | 1 = ACK, 0 = NACK |
| cmd_valid_o | output | 1 | One-cycle command handoff strobe |
| cmd_code_o | output | 8 | Command code |
| wr_len_o | output | $clog2(MAX_WR+1) | Write count M |
| wr_data_o | output | MAX_WR*8 | Payload; byte j at [8j+7:8j] |
| rsp_len_i | input | $clog2(MAX_RD+1) | Response count from handler (0 read as 1, clamped to MAX_RD) |
| rsp_data_i | input | MAX_RD*8 | Response bytes; byte k at [8k+7:8k] |
| tx_byte_o | output | 8 | Byte the front end shifts out next |

## Verification
The timeout abort and the repeated-start handoff can fall on the same clock edge. The bench holds scl_low_i high so that the timeout limit expires on exactly the edge that samples the repeated start. It then requires that no cmd_valid_o appears and that the next read address gets no response. In a control run the repeated start lands one edge earlier: cmd_valid_o must then pulse, and the abort on the following edge must still drop the read half.

// File: rtl/pcall_pkg.sv
`timescale 1ns/1ps
package pcall_pkg;
  typedef enum logic [1:0] {
    EV_RX    = 2'b00,
    EV_START = 2'b01,
    EV_STOP  = 2'b10,
    EV_TXD   = 2'b11
  } ev_kind_e;

  typedef enum logic [3:0] {
    S_IDLE, S_ADDR_W, S_CMD, S_WCNT, S_WDATA, S_IPEC, S_WAIT_RS,
    S_ADDR_R, S_RD_CNT, S_RD_DATA, S_RD_PEC, S_DONE
  } state_e;

  localparam logic [7:0] CRC_POLY = 8'h07;

  function automatic logic [7:0] crc8_step(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] r;
    r = c ^ d;
    for (int i = 0; i < 8; i++) r = r[7] ? ((r << 1) ^ CRC_POLY) : (r << 1);
    return r;
  endfunction
endpackage

// File: rtl/pcall_crc8.sv
`timescale 1ns/1ps
module pcall_crc8 (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       upd_i,
  input  logic [7:0] byte_i,
  output logic [7:0] crc_o,
  output logic [7:0] crc_nxt_o
);
  logic [7:0] crc_q;

  assign crc_nxt_o = pcall_pkg::crc8_step(crc_q, byte_i);
  assign crc_o     = crc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     crc_q <= 8'h00;
    else if (clr_i)  crc_q <= 8'h00;
    else if (upd_i)  crc_q <= crc_nxt_o;
  end
endmodule

// File: rtl/pcall_timeout.sv
`timescale 1ns/1ps
module pcall_timeout #(
  parameter int unsigned TO_CYC = 1250000,
  localparam int unsigned CW = $clog2(TO_CYC + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_low_i,
  output logic hit_o
);
  logic [CW-1:0] cnt_q;

  // fires once, on the TO_CYC-th consecutive low edge
  assign hit_o = scl_low_i && (cnt_q == CW'(TO_CYC - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (!scl_low_i)             cnt_q <= '0;
    else if (cnt_q != CW'(TO_CYC))   cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/pcall_bytebuf.sv
`timescale 1ns/1ps
module pcall_bytebuf #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned IW    = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [IW-1:0]      idx_i,
  input  logic [7:0]         byte_i,
  output logic [DEPTH*8-1:0] data_o
);
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic [7:0] slot_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          slot_q <= 8'h00;
      else if (we_i && idx_i == IW'(g))     slot_q <= byte_i;
    end
    assign data_o[g*8 +: 8] = slot_q;
  end
endmodule

// File: rtl/pcall_engine.sv
`timescale 1ns/1ps
module pcall_engine
  import pcall_pkg::*;
#(
  parameter int unsigned MAX_WR = 8,
  parameter int unsigned MAX_RD = 8,
  parameter int unsigned TO_CYC = 1250000,
  localparam int unsigned WIW = $clog2(MAX_WR + 1),
  localparam int unsigned RIW = $clog2(MAX_RD + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                ev_valid_i,
  input  logic [1:0]          ev_kind_i,
  input  logic [7:0]          ev_byte_i,
  input  logic                scl_low_i,
  input  logic                pec_en_i,
  input  logic [6:0]          own_addr_i,
  output logic                ack_valid_o,
  output logic                ack_o,
  output logic                cmd_valid_o,
  output logic [7:0]          cmd_code_o,
  output logic [WIW-1:0]      wr_len_o,
  output logic [MAX_WR*8-1:0] wr_data_o,
  input  logic [RIW-1:0]      rsp_len_i,
  input  logic [MAX_RD*8-1:0] rsp_data_i,
  output logic [7:0]          tx_byte_o
);
  localparam logic [7:0] MAX_WR_B = 8'(MAX_WR);

  state_e         state_q, state_d;
  logic           ack_v_d, ack_d, cmd_v_d;
  logic           cmd_we, wlen_we, wb_we, rd_we;
  logic [WIW-1:0] wlen_q, widx_q, widx_d;
  logic [RIW-1:0] rlen_q, rlen_d, ridx_q, ridx_d, rlen_eff;
  logic [7:0]     tx_q, tx_d;
  logic [7:0]     rbuf_q [MAX_RD];
  logic           crc_clr, crc_upd;
  logic [7:0]     crc_byte, crc_q, crc_nxt;
  logic           to_hit;

  logic ev_rx, ev_st, ev_sp, ev_tx, m_nack;
  assign ev_rx  = ev_valid_i && ev_kind_i == EV_RX;
  assign ev_st  = ev_valid_i && ev_kind_i == EV_START;
  assign ev_sp  = ev_valid_i && ev_kind_i == EV_STOP;
  assign ev_tx  = ev_valid_i && ev_kind_i == EV_TXD;
  assign m_nack = ev_byte_i[0];

  assign crc_byte = ev_tx ? tx_q : ev_byte_i;

  always_comb begin
    if (rsp_len_i == '0)                 rlen_eff = RIW'(1);
    else if (rsp_len_i > RIW'(MAX_RD))   rlen_eff = RIW'(MAX_RD);
    else                                 rlen_eff = rsp_len_i;
  end

  pcall_crc8 u_crc (
    .clk_i, .rst_ni,
    .clr_i(crc_clr), .upd_i(crc_upd), .byte_i(crc_byte),
    .crc_o(crc_q), .crc_nxt_o(crc_nxt)
  );

  pcall_timeout #(.TO_CYC(TO_CYC)) u_tmo (
    .clk_i, .rst_ni, .scl_low_i, .hit_o(to_hit)
  );

  pcall_bytebuf #(.DEPTH(MAX_WR), .IW(WIW)) u_wbuf (
    .clk_i, .rst_ni,
    .we_i(wb_we), .idx_i(widx_q), .byte_i(ev_byte_i), .data_o(wr_data_o)
  );

  always_comb begin
    state_d = state_q;
    ack_v_d = 1'b0;
    ack_d   = 1'b0;
    cmd_v_d = 1'b0;
    cmd_we  = 1'b0;
    wlen_we = 1'b0;
    wb_we   = 1'b0;
    rd_we   = 1'b0;
    crc_clr = 1'b0;
    crc_upd = 1'b0;
    widx_d  = widx_q;
    ridx_d  = ridx_q;
    rlen_d  = rlen_q;
    tx_d    = tx_q;
    if (to_hit || ev_sp) begin
      state_d = S_IDLE;
      tx_d    = 8'hFF;
    end else if (ev_st) begin
      tx_d = 8'hFF;
      unique case (state_q)
        S_WAIT_RS: begin
          cmd_v_d = 1'b1;
          state_d = S_ADDR_R;
        end
        S_IDLE, S_DONE: begin
          crc_clr = 1'b1;
          state_d = S_ADDR_W;
        end
        default: state_d = S_IDLE;
      endcase
    end else if (ev_rx) begin
      unique case (state_q)
        S_IDLE, S_DONE: ;
        S_ADDR_W: begin
          ack_v_d = 1'b1;
          if (ev_byte_i == {own_addr_i, 1'b0}) begin
            ack_d = 1'b1; crc_upd = 1'b1; state_d = S_CMD;
          end else state_d = S_IDLE;
        end
        S_CMD: begin
          ack_v_d = 1'b1; ack_d = 1'b1; crc_upd = 1'b1; cmd_we = 1'b1;
          state_d = S_WCNT;
        end
        S_WCNT: begin
          ack_v_d = 1'b1;
          if (ev_byte_i != 8'h00 && ev_byte_i <= MAX_WR_B) begin
            ack_d = 1'b1; crc_upd = 1'b1; wlen_we = 1'b1;
            widx_d = '0; state_d = S_WDATA;
          end else state_d = S_IDLE;
        end
        S_WDATA: begin
          ack_v_d = 1'b1; ack_d = 1'b1; crc_upd = 1'b1; wb_we = 1'b1;
          widx_d = widx_q + 1'b1;
          if (widx_q == wlen_q - 1'b1) state_d = pec_en_i ? S_IPEC : S_WAIT_RS;
        end
        S_IPEC: begin
          ack_v_d = 1'b1;
          // intermediate byte checked but never folded into the running CRC
          if (ev_byte_i == crc_q) begin
            ack_d = 1'b1; state_d = S_WAIT_RS;
          end else state_d = S_IDLE;
        end
        S_ADDR_R: begin
          ack_v_d = 1'b1;
          if (ev_byte_i == {own_addr_i, 1'b1}) begin
            ack_d = 1'b1; crc_upd = 1'b1; rd_we = 1'b1;
            rlen_d = rlen_eff; tx_d = 8'(rlen_eff); state_d = S_RD_CNT;
          end else state_d = S_IDLE;
        end
        default: begin
          ack_v_d = 1'b1;
          state_d = S_IDLE;
        end
      endcase
    end else if (ev_tx) begin
      unique case (state_q)
        S_IDLE, S_DONE: ;
        S_RD_CNT: begin
          if (m_nack) begin
            state_d = S_DONE; tx_d = 8'hFF;
          end else begin
            crc_upd = 1'b1; ridx_d = '0; tx_d = rbuf_q[0]; state_d = S_RD_DATA;
          end
        end
        S_RD_DATA: begin
          if (m_nack) begin
            state_d = S_DONE; tx_d = 8'hFF;
          end else begin
            crc_upd = 1'b1;
            if (ridx_q == rlen_q - 1'b1) begin
              tx_d = crc_nxt; state_d = S_RD_PEC;
            end else begin
              ridx_d = ridx_q + 1'b1; tx_d = rbuf_q[ridx_q + 1'b1];
            end
          end
        end
        S_RD_PEC: begin
          state_d = S_DONE; tx_d = 8'hFF;
        end
        default: state_d = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= S_IDLE;
      ack_valid_o <= 1'b0;
      ack_o       <= 1'b0;
      cmd_valid_o <= 1'b0;
      cmd_code_o  <= 8'h00;
      wlen_q      <= '0;
      widx_q      <= '0;
      ridx_q      <= '0;
      rlen_q      <= '0;
      tx_q        <= 8'hFF;
    end else begin
      state_q     <= state_d;
      ack_valid_o <= ack_v_d;
      ack_o       <= ack_d;
      cmd_valid_o <= cmd_v_d;
      if (cmd_we)  cmd_code_o <= ev_byte_i;
      if (wlen_we) wlen_q     <= WIW'(ev_byte_i);
      widx_q      <= widx_d;
      ridx_q      <= ridx_d;
      rlen_q      <= rlen_d;
      tx_q        <= tx_d;
    end
  end

  for (genvar k = 0; k < MAX_RD; k++) begin : g_rbuf
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    rbuf_q[k] <= 8'h00;
      else if (rd_we) rbuf_q[k] <= rsp_data_i[k*8 +: 8];
    end
  end

  assign wr_len_o  = wlen_q;
  assign tx_byte_o = tx_q;
endmodule

// File: rtl/pcall_engine_chk.sv
`timescale 1ns/1ps
module pcall_engine_chk
  import pcall_pkg::*;
#(
  parameter int unsigned MAX_WR = 8,
  localparam int unsigned WIW = $clog2(MAX_WR + 1)
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           ev_valid_i,
  input logic [1:0]     ev_kind_i,
  input logic           ack_valid_o,
  input logic           cmd_valid_o,
  input logic [WIW-1:0] wr_len_o,
  input logic [7:0]     tx_byte_o,
  input logic           to_hit_i,
  input state_e         state_i
);
  // R2
  ack_after_rx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_valid_o |-> $past(ev_valid_i && ev_kind_i == EV_RX));

  // R6
  cmd_after_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> $past(ev_valid_i && ev_kind_i == EV_START));

  // R6
  cmd_len_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> (wr_len_o != '0 && wr_len_o <= WIW'(MAX_WR)));

  // R9
  stop_to_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_valid_i && ev_kind_i == EV_STOP) |=> (state_i == S_IDLE && !cmd_valid_o));

  // R10
  tmo_abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    to_hit_i |=> (state_i == S_IDLE && !cmd_valid_o && !ack_valid_o && tx_byte_o == 8'hFF));
endmodule

bind pcall_engine pcall_engine_chk #(.MAX_WR(MAX_WR)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ev_valid_i(ev_valid_i), .ev_kind_i(ev_kind_i),
  .ack_valid_o(ack_valid_o), .cmd_valid_o(cmd_valid_o), .wr_len_o(wr_len_o),
  .tx_byte_o(tx_byte_o), .to_hit_i(to_hit), .state_i(state_q)
);

// File: tb/pcall_engine_test.sv
`timescale 1ns/1ps
module pcall_engine_test;
  localparam int MW = 4, MR = 4, TO = 16;
  localparam int WW = $clog2(MW + 1), RW = $clog2(MR + 1);
  localparam logic [6:0] OWN = 7'h3C;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ev_valid = 1'b0, scl_low = 1'b0, pec_en = 1'b0;
  logic [1:0] ev_kind = 2'b00;
  logic [7:0] ev_byte = 8'h00;
  logic ack_valid, ack, cmd_valid;
  logic [7:0] cmd_code, tx_byte;
  logic [WW-1:0] wr_len;
  logic [MW*8-1:0] wr_data;
  logic [RW-1:0] rsp_len;
  logic [MR*8-1:0] rsp_data;
  int n_chk = 0, n_err = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  pcall_engine #(.MAX_WR(MW), .MAX_RD(MR), .TO_CYC(TO)) uut (
    .clk_i(clk), .rst_ni(rst_n), .ev_valid_i(ev_valid), .ev_kind_i(ev_kind),
    .ev_byte_i(ev_byte), .scl_low_i(scl_low), .pec_en_i(pec_en), .own_addr_i(OWN),
    .ack_valid_o(ack_valid), .ack_o(ack), .cmd_valid_o(cmd_valid), .cmd_code_o(cmd_code),
    .wr_len_o(wr_len), .wr_data_o(wr_data), .rsp_len_i(rsp_len), .rsp_data_i(rsp_data),
    .tx_byte_o(tx_byte)
  );

  // handler model: length and data derived from the command it was handed
  always_comb begin
    rsp_len = RW'(cmd_code[1:0]) + RW'(1);
    for (int k = 0; k < MR; k++) rsp_data[k*8 +: 8] = cmd_code ^ (8'h11 * 8'(k)) ^ wr_data[7:0];
  end

  function automatic logic [7:0] crc_m(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] r = c ^ d;
    for (int i = 0; i < 8; i++) r = r[7] ? ((r << 1) ^ 8'h07) : (r << 1);
    return r;
  endfunction

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic put(input logic [1:0] k, input logic [7:0] b);
    ev_valid = 1'b1; ev_kind = k; ev_byte = b;
    @(negedge clk);
    ev_valid = 1'b0;
  endtask

  task automatic rx(input logic [7:0] b, input logic ea, input string tag);
    put(2'b00, b);
    chk(ack_valid === 1'b1 && ack === ea, tag, {ack_valid, ack}, {1'b1, ea});
  endtask

  task automatic rx_none(input logic [7:0] b, input string tag);
    put(2'b00, b);
    chk(ack_valid === 1'b0, tag, ack_valid, 0);
  endtask

  task automatic txb(input logic [7:0] e, input logic nack, input string tag);
    chk(tx_byte === e, tag, tx_byte, e);
    put(2'b11, {7'b0, nack});
  endtask

  logic [7:0] wd [MW];

  task automatic wr_half(input logic pe, input logic [7:0] c, input int m,
                         input logic [7:0] seed, output logic [7:0] crc);
    crc = 8'h00;
    pec_en = pe;
    put(2'b01, 8'h00);
    rx({OWN, 1'b0}, 1'b1, "R1 write address"); crc = crc_m(crc, {OWN, 1'b0});
    rx(c, 1'b1, "R2 command");                 crc = crc_m(crc, c);
    rx(8'(m), 1'b1, "R2 count");                crc = crc_m(crc, 8'(m));
    for (int j = 0; j < m; j++) begin
      wd[j] = seed + 8'(j) * 8'd37;
      rx(wd[j], 1'b1, "R2 payload");
      crc = crc_m(crc, wd[j]);
    end
    if (pe) rx(crc, 1'b1, "R4 R3 intermediate crc match");
  endtask

  task automatic txn(input logic pe, input logic [7:0] c, input int m, input logic [7:0] seed);
    logic [7:0] crc, d0;
    int n;
    wr_half(pe, c, m, seed, crc);
    put(2'b01, 8'h00);
    chk(cmd_valid === 1'b1, "R6 handoff strobe", cmd_valid, 1);
    chk(cmd_code === c, "R6 command code", cmd_code, c);
    chk(wr_len === WW'(m), "R6 write count", wr_len, m);
    for (int j = 0; j < m; j++)
      chk(wr_data[j*8 +: 8] === wd[j], "R6 payload byte", wr_data[j*8 +: 8], wd[j]);
    rx({OWN, 1'b1}, 1'b1, "R7 read address"); crc = crc_m(crc, {OWN, 1'b1});
    chk(cmd_valid === 1'b0, "R6 strobe one cycle", cmd_valid, 0);
    n = int'(c[1:0]) + 1;
    d0 = wd[0];
    txb(8'(n), 1'b0, "R7 count byte"); crc = crc_m(crc, 8'(n));
    for (int k = 0; k < n; k++) begin
      logic [7:0] e = c ^ (8'h11 * 8'(k)) ^ d0;
      txb(e, 1'b0, "R7 response byte");
      crc = crc_m(crc, e);
    end
    txb(crc, 1'b1, "R8 R3 closing crc");
    chk(tx_byte === 8'hFF, "R7 idle fill after crc", tx_byte, 8'hFF);
    put(2'b10, 8'h00);
  endtask

  initial begin
    logic [7:0] crc;
    repeat (3) @(negedge clk);
    // R11
    chk(ack_valid === 1'b0 && cmd_valid === 1'b0, "R11 reset strobes", {ack_valid, cmd_valid}, 0);
    chk(tx_byte === 8'hFF, "R11 reset tx", tx_byte, 8'hFF);
    rst_n = 1'b1;
    @(negedge clk);

    // sweep: both integrity modes, all write counts, several commands
    for (int pe = 0; pe < 2; pe++)
      for (int m = 1; m <= MW; m++)
        for (int ci = 0; ci < 4; ci++)
          txn(pe[0], 8'(8'h5B * ci + m), m, 8'(8'h19 * m + ci));

    // R1 wrong address, then read-bit address first
    put(2'b01, 8'h00);
    rx({OWN ^ 7'h01, 1'b0}, 1'b0, "R1 foreign address nack");
    rx_none(8'h12, "R1 no response after nack");
    put(2'b10, 8'h00);
    put(2'b01, 8'h00);
    rx({OWN, 1'b1}, 1'b0, "R1 read bit first nack");
    put(2'b10, 8'h00);

    // R2 count out of range
    put(2'b01, 8'h00);
    rx({OWN, 1'b0}, 1'b1, "R2 address");
    rx(8'h40, 1'b1, "R2 command");
    rx(8'h00, 1'b0, "R2 zero count nack");
    put(2'b10, 8'h00);
    put(2'b01, 8'h00);
    rx({OWN, 1'b0}, 1'b1, "R2 address");
    rx(8'h40, 1'b1, "R2 command");
    rx(8'(MW + 1), 1'b0, "R2 oversize count nack");
    put(2'b10, 8'h00);

    // R4 bad intermediate crc
    pec_en = 1'b1;
    put(2'b01, 8'h00);
    rx({OWN, 1'b0}, 1'b1, "R4 address");
    rx(8'h77, 1'b1, "R4 command");
    rx(8'h01, 1'b1, "R4 count");
    rx(8'hA5, 1'b1, "R4 payload");
    crc = crc_m(crc_m(crc_m(crc_m(8'h00, {OWN, 1'b0}), 8'h77), 8'h01), 8'hA5);
    rx(crc ^ 8'h01, 1'b0, "R4 crc mismatch nack");
    put(2'b01, 8'h00);
    chk(cmd_valid === 1'b0, "R4 no handoff after mismatch", cmd_valid, 0);
    put(2'b10, 8'h00);

    // R5 byte in the integrity slot when disabled
    wr_half(1'b0, 8'h33, 2, 8'h10, crc);
    rx(crc, 1'b0, "R5 unexpected slot byte nack");
    put(2'b01, 8'h00);
    chk(cmd_valid === 1'b0, "R5 frame dropped", cmd_valid, 0);
    put(2'b10, 8'h00);

    // R9 stop mid-frame
    pec_en = 1'b0;
    put(2'b01, 8'h00);
    rx({OWN, 1'b0}, 1'b1, "R9 address");
    rx(8'h21, 1'b1, "R9 command");
    rx(8'h02, 1'b1, "R9 count");
    rx(8'h01, 1'b1, "R9 payload");
    put(2'b10, 8'h00);
    put(2'b01, 8'h00);
    chk(cmd_valid === 1'b0, "R9 stop dropped frame", cmd_valid, 0);
    rx({OWN, 1'b1}, 1'b0, "R9 new frame expects write bit");
    put(2'b10, 8'h00);
    // R9 start mid-frame
    put(2'b01, 8'h00);
    rx({OWN, 1'b0}, 1'b1, "R9 address");
    rx(8'h21, 1'b1, "R9 command");
    put(2'b01, 8'h00);
    chk(cmd_valid === 1'b0, "R9 stray start no handoff", cmd_valid, 0);
    rx_none({OWN, 1'b0}, "R9 idle after stray start");
    put(2'b10, 8'h00);

    // R7 master nack after count
    wr_half(1'b0, 8'h02, 1, 8'h44, crc);
    put(2'b01, 8'h00);
    rx({OWN, 1'b1}, 1'b1, "R7 read address");
    txb(8'h03, 1'b1, "R7 count before nack");
    chk(tx_byte === 8'hFF, "R7 fill after master nack", tx_byte, 8'hFF);
    put(2'b10, 8'h00);

    // R10 timeout expiring on the repeated-start edge
    wr_half(1'b0, 8'h01, 1, 8'h09, crc);
    scl_low = 1'b1;
    repeat (TO - 1) @(negedge clk);
    put(2'b01, 8'h00);
    chk(cmd_valid === 1'b0, "R10 timeout beats repeated start", cmd_valid, 0);
    scl_low = 1'b0;
    rx_none({OWN, 1'b1}, "R10 idle after timeout");
    put(2'b10, 8'h00);
    // control: repeated start one edge earlier
    wr_half(1'b0, 8'h01, 1, 8'h09, crc);
    scl_low = 1'b1;
    repeat (TO - 2) @(negedge clk);
    put(2'b01, 8'h00);
    chk(cmd_valid === 1'b1, "R10 start before expiry hands off", cmd_valid, 1);
    rx_none({OWN, 1'b1}, "R10 abort drops read half");
    scl_low = 1'b0;
    put(2'b10, 8'h00);

    // engine still usable afterwards
    txn(1'b1, 8'hC6, 3, 8'h5E);

    if (!finished) begin
      finished = 1;
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule